// File: doc/BRIEF.md
# Pulse Level Duration Capture

This block times an asynchronous, already demodulated serial data line. It measures how long each high phase and each low phase lasts, in ticks of a prescaled time base, and reports every completed phase as an event: a one-cycle valid strobe, the level that just ended, and a 32-bit duration.

One counter does all the timing. It runs on the prescaled tick and is cleared by every rising edge of the line. A falling edge captures the counter as the high time. The next rising edge captures the counter as the full period, and the low time is reported as that period minus the stored high time. The line is synchronised to the local clock before any edge is looked at. While the enable input is low, the counter and the prescaler rest at zero and nothing is reported, so each enabled run starts timing from zero.

Top module: `pulse_duration_capture`

## Requirements
- R1: After reset, evtValid, evtLevel and evtDuration are all 0.
- R2: The data line passes two synchroniser flops before edge detection. An event appears on the outputs at the third rising clock edge after the first edge that samples the new line level.
- R3: The time base ticks once every prescale+1 clocks. A phase that lasts C clocks is reported as floor(C / (prescale+1)) ticks. A rising edge restarts the prescaler, and the edge cycle counts as the first clock of the new phase.
- R4: A falling edge reports an event with evtLevel = 1 and a duration equal to the counter value, and it stores that value as the high time.
- R5: A rising edge clears the counter and reports an event with evtLevel = 0 and a duration equal to the counter value minus the stored high time, taken modulo 2^32.
- R6: The stored high time is 0 after enabling and after every rising edge. The first rising edge of a run with no falling edge before it therefore reports the whole time since enable.
- R7: The counter never exceeds CNT_LIMIT (default 0x7FFFFFFE). A tick taken at CNT_LIMIT wraps the counter to 0.
- R8: While enable is 0, the counter and the prescaler are held at 0 and no events are produced. Enabling while the line is already high produces no event.
- R9: Each detected edge gives exactly one single-cycle evtValid pulse. Within one enabled run, the levels of successive events alternate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run enable; when low, timing is held at zero |
| dataIn | input | 1 | Asynchronous demodulated data line |
| prescale | input | PRE_W (16) | Tick divider minus one |
| evtValid | output | 1 | One-cycle strobe for a completed phase |
| evtLevel | output | 1 | Level of the completed phase (1 = high) |
| evtDuration | output | CNT_W (32) | Phase length in ticks |

## Verification
The bench uses prescaler settings of 0, 1, 2 and 3 with phase lengths that do not divide evenly, so a prescaler that is restarted off by one cycle shows up as a wrong floor value. One-clock high and low pulses check that a fall followed at once by a rise still gives two separate events. Enabling with the line already high catches a design that reports a phantom rise. A high phase longer than the counter limit of the bench instance checks the wrap, and a following low time that comes out right shows the subtraction is done modulo the counter. The timing of the falling-edge event is checked against the synchroniser latency, so a missing or extra flop in the synchroniser fails that check.

// File: rtl/pdc_pkg.sv
package pdc_pkg;

  // Strobes from control to datapath, valid for one clock
  typedef struct packed {
    logic hold;   // run disabled: park counter, prescaler and high store
    logic rise;   // synchronised rising edge seen this cycle
    logic fall;   // synchronised falling edge seen this cycle
  } pdcStrobe_t;

endpackage

// File: rtl/pdc_sync.sv
module pdc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] stage;

  generate
    if (STAGES == 1) begin : gSingle
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage <= '0;
        else       stage <= din;
      end
    end else begin : gChain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage <= '0;
        else       stage <= {stage[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = stage[STAGES-1];

endmodule

// File: rtl/pdc_ctrl.sv
module pdc_ctrl
  import pdc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       dataIn,
  output pdcStrobe_t strobes
);

  logic syncLevel;
  logic prevLevel;
  logic riseSeen;
  logic fallSeen;

  pdc_sync #(.STAGES(SYNC_STAGES)) uSync (
    .clk  (clk),
    .rstN (rstN),
    .din  (dataIn),
    .dout (syncLevel)
  );

  // The previous level follows the line even while disabled, so that
  // enabling on a high line is not mistaken for a rising edge.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevLevel <= 1'b0;
    else       prevLevel <= syncLevel;
  end

  assign riseSeen = syncLevel & ~prevLevel;
  assign fallSeen = ~syncLevel & prevLevel;

  always_comb begin
    strobes.hold = ~enable;
    strobes.rise = enable & riseSeen;
    strobes.fall = enable & fallSeen;
  end

endmodule

// File: rtl/pdc_datapath.sv
module pdc_datapath
  import pdc_pkg::*;
#(
  parameter int              CNT_W     = 32,
  parameter int              PRE_W     = 16,
  parameter logic [CNT_W-1:0] CNT_LIMIT = 32'h7FFF_FFFE
) (
  input  logic             clk,
  input  logic             rstN,
  input  pdcStrobe_t       strobes,
  input  logic [PRE_W-1:0] prescale,
  output logic             evtValid,
  output logic             evtLevel,
  output logic [CNT_W-1:0] evtDuration,
  output logic [CNT_W-1:0] tickCount
);

  localparam logic [PRE_W-1:0] PRE_ONE = PRE_W'(1);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [PRE_W-1:0] presCnt;
  logic [CNT_W-1:0] highCap;
  logic             tickNow;
  logic             singleClk;
  logic [CNT_W-1:0] cntAdvanced;
  logic [PRE_W-1:0] presAdvanced;

  assign singleClk    = (prescale == '0);
  assign tickNow      = (presCnt >= prescale);
  assign presAdvanced = tickNow ? '0 : presCnt + PRE_ONE;
  assign cntAdvanced  = !tickNow ? tickCount
                      : (tickCount >= CNT_LIMIT) ? '0 : tickCount + CNT_ONE;

  // Prescaler and tick counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      presCnt   <= '0;
      tickCount <= '0;
    end else if (strobes.hold) begin
      presCnt   <= '0;
      tickCount <= '0;
    end else if (strobes.rise) begin
      // The edge cycle is the first clock of the new phase
      presCnt   <= singleClk ? '0 : PRE_ONE;
      tickCount <= singleClk ? CNT_ONE : '0;
    end else begin
      presCnt   <= presAdvanced;
      tickCount <= cntAdvanced;
    end
  end

  // Stored high time
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            highCap <= '0;
    else if (strobes.hold || strobes.rise) highCap <= '0;
    else if (strobes.fall)                highCap <= tickCount;
  end

  // Event register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evtValid    <= 1'b0;
      evtLevel    <= 1'b0;
      evtDuration <= '0;
    end else begin
      evtValid <= ~strobes.hold & (strobes.rise | strobes.fall);
      if (!strobes.hold && strobes.fall) begin
        evtLevel    <= 1'b1;
        evtDuration <= tickCount;
      end else if (!strobes.hold && strobes.rise) begin
        evtLevel    <= 1'b0;
        evtDuration <= tickCount - highCap;
      end
    end
  end

endmodule

// File: rtl/pulse_duration_capture.sv
module pulse_duration_capture
  import pdc_pkg::*;
#(
  parameter int               CNT_W       = 32,
  parameter int               PRE_W       = 16,
  parameter int               SYNC_STAGES = 2,
  parameter logic [CNT_W-1:0] CNT_LIMIT   = 32'h7FFF_FFFE
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             dataIn,
  input  logic [PRE_W-1:0] prescale,
  output logic             evtValid,
  output logic             evtLevel,
  output logic [CNT_W-1:0] evtDuration
);

  pdcStrobe_t       strobes;
  logic [CNT_W-1:0] tickCount;

  pdc_ctrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .enable  (enable),
    .dataIn  (dataIn),
    .strobes (strobes)
  );

  pdc_datapath #(
    .CNT_W     (CNT_W),
    .PRE_W     (PRE_W),
    .CNT_LIMIT (CNT_LIMIT)
  ) uPath (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .prescale    (prescale),
    .evtValid    (evtValid),
    .evtLevel    (evtLevel),
    .evtDuration (evtDuration),
    .tickCount   (tickCount)
  );

endmodule

// File: rtl/pdc_checker.sv
module pdc_checker #(
  parameter int               CNT_W     = 32,
  parameter logic [CNT_W-1:0] CNT_LIMIT = 32'h7FFF_FFFE
) (
  input logic             clk,
  input logic             rstN,
  input logic             enable,
  input logic             dataIn,
  input logic             evtValid,
  input logic             evtLevel,
  input logic [CNT_W-1:0] tickCount
);

  logic lastLevel;
  logic haveLast;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastLevel <= 1'b0;
      haveLast  <= 1'b0;
    end else if (!enable) begin
      haveLast <= 1'b0;
    end else if (evtValid) begin
      lastLevel <= evtLevel;
      haveLast  <= 1'b1;
    end
  end

  // R8
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !evtValid);

  // R8
  disabled_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (tickCount == '0));

  // R4 (with R2 latency: line was low three edges earlier)
  high_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evtValid && evtLevel) |-> ($past(dataIn, 3) == 1'b0));

  // R5 (with R2 latency: line was high three edges earlier)
  low_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evtValid && !evtLevel) |-> ($past(dataIn, 3) == 1'b1));

  // R7
  count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    tickCount <= CNT_LIMIT);

  // R9
  alternate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evtValid && haveLast && enable) |-> (evtLevel != lastLevel));

endmodule

bind pulse_duration_capture pdc_checker #(
  .CNT_W     (CNT_W),
  .CNT_LIMIT (CNT_LIMIT)
) chk (
  .clk       (clk),
  .rstN      (rstN),
  .enable    (enable),
  .dataIn    (dataIn),
  .evtValid  (evtValid),
  .evtLevel  (evtLevel),
  .tickCount (tickCount)
);

// File: tb/tb_pulse_duration_capture.sv
module tb_pulse_duration_capture;

  localparam int          CNT_W = 32;
  localparam int          PRE_W = 16;
  localparam int          LIMIT = 200;
  localparam int          NVEC  = 6;
  // {prescale, high clocks, low clocks}
  localparam int VEC [NVEC][3] = '{
    '{0, 10, 7}, '{1, 9, 6}, '{3, 20, 13},
    '{0, 1, 1},  '{2, 2, 3}, '{1, 17, 2}
  };

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             enable = 1'b0;
  logic             dataIn = 1'b0;
  logic [PRE_W-1:0] prescale = '0;
  logic             evtValid;
  logic             evtLevel;
  logic [CNT_W-1:0] evtDuration;

  int checks = 0;
  int fails = 0;
  int cycNow = 0;
  bit done = 0;
  int logCount = 0;
  logic             logLvl [16];
  logic [CNT_W-1:0] logDur [16];
  int               logCyc [16];

  pulse_duration_capture #(
    .CNT_W(CNT_W), .PRE_W(PRE_W), .CNT_LIMIT(CNT_W'(LIMIT))
  ) dut (
    .clk(clk), .rstN(rstN), .enable(enable), .dataIn(dataIn),
    .prescale(prescale), .evtValid(evtValid), .evtLevel(evtLevel),
    .evtDuration(evtDuration)
  );

  always #10 clk = ~clk;

  always @(posedge clk) cycNow++;

  always @(negedge clk) begin
    if (rstN && evtValid && logCount < 16) begin
      logLvl[logCount] = evtLevel;
      logDur[logCount] = evtDuration;
      logCyc[logCount] = cycNow;
      logCount++;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [CNT_W-1:0] ticks(input int clocks, input int p);
    return CNT_W'((clocks / (p + 1)) % (LIMIT + 1));
  endfunction

  task automatic runVector(input int p, input int h, input int l, input string tag);
    logic [CNT_W-1:0] expHigh, expLow;
    int fallCyc;
    enable = 1'b0; dataIn = 1'b0; prescale = PRE_W'(p);
    cyc(4);
    logCount = 0;
    enable = 1'b1;
    cyc(3);
    dataIn = 1'b1;
    cyc(h);
    dataIn = 1'b0;
    fallCyc = cycNow;
    cyc(l);
    dataIn = 1'b1;
    cyc(5);
    dataIn = 1'b0;
    cyc(12);
    enable = 1'b0;
    expHigh = ticks(h, p);
    expLow  = ticks(h + l, p) - expHigh;
    check(logCount == 4, {tag, " R9 event count"}, logCount, 4);
    if (logCount == 4) begin
      check(logLvl[0] == 1'b0, {tag, " R6 first level"}, logLvl[0], 0);
      check(logDur[0] == ticks(5, p), {tag, " R6 since-enable low"}, logDur[0], ticks(5, p));
      check(logLvl[1] == 1'b1, {tag, " R4 high level"}, logLvl[1], 1);
      check(logDur[1] == expHigh, {tag, " R3 R4 high duration"}, logDur[1], expHigh);
      check(logCyc[1] == fallCyc + 3, {tag, " R2 fall latency"}, logCyc[1] - fallCyc, 3);
      check(logLvl[2] == 1'b0, {tag, " R5 low level"}, logLvl[2], 0);
      check(logDur[2] == expLow, {tag, " R3 R5 low duration"}, logDur[2], expLow);
      check(logDur[3] == ticks(5, p), {tag, " R5 counter cleared on rise"}, logDur[3], ticks(5, p));
    end
  endtask

  initial begin
    cyc(3);
    // R1 reset state
    check(evtValid == 1'b0, "R1 valid", evtValid, 0);
    check(evtLevel == 1'b0, "R1 level", evtLevel, 0);
    check(evtDuration == '0, "R1 duration", evtDuration, 0);
    rstN = 1'b1;
    cyc(3);

    for (int i = 0; i < NVEC; i++)
      runVector(VEC[i][0], VEC[i][1], VEC[i][2], "vec");

    // R7 high phase longer than the counter limit
    runVector(0, 250, 4, "R7 wrap");

    // R8 edges while disabled give nothing
    enable = 1'b0; prescale = '0; logCount = 0;
    for (int k = 0; k < 6; k++) begin
      dataIn = ~dataIn;
      cyc(4);
    end
    dataIn = 1'b0;
    cyc(6);
    check(logCount == 0, "R8 disabled events", logCount, 0);

    // R8 enabling on a high line: no rise event, high counted from enable
    dataIn = 1'b1;
    cyc(4);
    logCount = 0;
    enable = 1'b1;
    cyc(7);
    dataIn = 1'b0;
    cyc(8);
    check(logCount == 1, "R8 enable-high event count", logCount, 1);
    if (logCount == 1) begin
      check(logLvl[0] == 1'b1, "R8 enable-high level", logLvl[0], 1);
      check(logDur[0] == 9, "R8 enable-high duration", logDur[0], 9);
    end
    enable = 1'b0;
    cyc(2);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule